// File: doc/BRIEF.md
# Counting Semaphore Bank with Sleeping Waiters

A bank of counting semaphores shared by a fixed set of hardware threads. Each semaphore holds an unsigned count that can be raised from three kinds of event: a set issued by a local thread, a set arriving as a command from the network, and the arrival of a data packet tagged with that semaphore. Packets may arrive in any order, so a consumer learns that a transfer has completed by counting its arrivals. All increments that reach one semaphore in a cycle are summed and applied as one atomic update.

A thread waits by naming a semaphore and a threshold. Its controller then moves from state IDLE to state SLEEP (transition "wait accepted"), and the thread scheduler keeps it parked while `thr_asleep` is high. When the count reaches the threshold, a round-robin arbiter for that semaphore grants one sleeper. The `thr_wake` output pulses for one cycle, the threshold is subtracted from the count at the same clock edge, and the controller returns from SLEEP to IDLE (transition "granted"). Waiters on the same semaphore are served in rotation, starting with the thread after the one granted last, so none of them can starve. A count that would pass its maximum is clamped there and sets a sticky overflow flag.

Top module: `sem_bank`

## Requirements
- R1: After reset every count is 0, no thread is asleep, no wake is pulsed and no overflow flag is set.
- R2: A local set from any thread raises the named semaphore's count by one, and the new value is visible after the next clock edge.
- R3: A remote set command and a packet arrival each raise the named semaphore's count by one. Events naming different semaphores in the same cycle update each of them independently.
- R4: All increments naming one semaphore in the same cycle (up to every local thread, plus the remote command and the packet) are summed into a single update. With four threads that is +6.
- R5: A wait issued by an IDLE thread sets `thr_asleep` from the next cycle. A wait issued while the thread is in SLEEP is ignored: the stored semaphore and threshold are kept.
- R6: A sleeping thread whose semaphore count is at least its threshold sees `thr_wake` high for exactly one cycle. At the next edge `thr_asleep` falls and the count becomes count − threshold + that cycle's increments.
- R7: At most one thread per semaphore is woken in a cycle. Among the eligible sleepers the grant goes to the first thread index after the last one granted on that semaphore, wrapping around; after reset the search starts at thread 0.
- R8: A count never exceeds 2^CNT_W−1. An update that would pass that value leaves the count at 2^CNT_W−1 and sets that semaphore's overflow flag, which stays set until reset.
- R9: A sleeping thread whose count is below its threshold stays asleep, and no wake is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_vld | input | NUM_THR | Per-thread local set strobe |
| set_sem | input | NUM_THR×SEM_W | Semaphore named by each local set |
| rmt_vld | input | 1 | Remote set command strobe |
| rmt_sem | input | SEM_W | Semaphore named by the remote set |
| pkt_vld | input | 1 | Tagged packet arrival strobe |
| pkt_sem | input | SEM_W | Semaphore tag of the arriving packet |
| wait_vld | input | NUM_THR | Per-thread wait request |
| wait_sem | input | NUM_THR×SEM_W | Semaphore each wait names |
| wait_thr | input | NUM_THR×CNT_W | Threshold each wait names |
| thr_asleep | output | NUM_THR | Thread is in SLEEP |
| thr_wake | output | NUM_THR | One-cycle wake pulse |
| sem_count | output | NUM_SEM×CNT_W | Current count of each semaphore |
| sem_ovf | output | NUM_SEM | Sticky saturation flag per semaphore |

## Verification
The collision that matters is a grant and an increment landing on the same semaphore in one cycle. The result then has to be the count minus the threshold plus the new arrivals, with nothing lost. The bench provokes this by arming a waiter whose threshold already equals the count and then driving a remote set to that semaphore during the cycle that shows the wake. It then checks that the count settles at exactly the arrivals of that cycle. A second collision, several waiters becoming eligible together, is provoked by raising one semaphore by four in a single cycle. There the bench judges that the wakes come one per cycle in rotation order.

// File: rtl/sem_pkg.sv
package sem_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SLEEP = 1'b1
    } thr_state_t;
endpackage

// File: rtl/sem_thread_fsm.sv
module sem_thread_fsm
    import sem_pkg::*;
#(
    parameter int SEM_W = 2,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wait_vld,
    input  logic [SEM_W-1:0] wait_sem,
    input  logic [CNT_W-1:0] wait_thr,
    input  logic             grant,
    output logic             asleep,
    output logic [SEM_W-1:0] sem_q,
    output logic [CNT_W-1:0] thr_q
);
    thr_state_t state_q, state_d;

    // state register with captured wait operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sem_q   <= '0;
            thr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && wait_vld) begin
                sem_q <= wait_sem;
                thr_q <= wait_thr;
            end
        end
    end

    // next-state: IDLE --wait accepted--> SLEEP --granted--> IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wait_vld) state_d = ST_SLEEP;
            ST_SLEEP: if (grant)    state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        asleep = (state_q == ST_SLEEP);
    end
endmodule

// File: rtl/sem_rr_arb.sv
module sem_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] pick;
    logic             found;

    always_comb begin
        gnt   = '0;
        found = 1'b0;
        pick  = last_q;
        for (int i = 1; i <= N; i++) begin
            int idx;
            idx = (int'(last_q) + i) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
                pick     = IDX_W'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     last_q <= IDX_W'(N - 1);
        else if (found) last_q <= pick;
    end
endmodule

// File: rtl/sem_counter.sv
module sem_counter #(
    parameter int CNT_W = 8,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    input  logic [CNT_W-1:0] sub,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam int SUM_W = CNT_W + INC_W + 1;
    localparam logic [SUM_W-1:0] MAXV = SUM_W'({CNT_W{1'b1}});

    logic [SUM_W-1:0] nxt;

    // sub never exceeds count: a grant needs count >= threshold
    always_comb begin
        nxt = SUM_W'(count) + SUM_W'(inc) - SUM_W'(sub);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (nxt > MAXV) begin
            count <= {CNT_W{1'b1}};
            ovf   <= 1'b1;
        end else begin
            count <= nxt[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
    parameter int NUM_SEM = 4,
    parameter int NUM_THR = 4,
    parameter int CNT_W   = 8,
    localparam int SEM_W  = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_THR-1:0]                set_vld,
    input  logic [NUM_THR-1:0][SEM_W-1:0]     set_sem,
    input  logic                              rmt_vld,
    input  logic [SEM_W-1:0]                  rmt_sem,
    input  logic                              pkt_vld,
    input  logic [SEM_W-1:0]                  pkt_sem,
    input  logic [NUM_THR-1:0]                wait_vld,
    input  logic [NUM_THR-1:0][SEM_W-1:0]     wait_sem,
    input  logic [NUM_THR-1:0][CNT_W-1:0]     wait_thr,
    output logic [NUM_THR-1:0]                thr_asleep,
    output logic [NUM_THR-1:0]                thr_wake,
    output logic [NUM_SEM-1:0][CNT_W-1:0]     sem_count,
    output logic [NUM_SEM-1:0]                sem_ovf
);
    localparam int INC_W = $clog2(NUM_THR + 3);

    logic [NUM_THR-1:0][SEM_W-1:0] sem_q;
    logic [NUM_THR-1:0][CNT_W-1:0] thr_q;
    logic [NUM_SEM-1:0][NUM_THR-1:0] req, gnt;
    logic [NUM_SEM-1:0][INC_W-1:0] inc;
    logic [NUM_SEM-1:0][CNT_W-1:0] sub;

    genvar t, s;

    generate
        for (t = 0; t < NUM_THR; t++) begin : g_thr
            sem_thread_fsm #(.SEM_W(SEM_W), .CNT_W(CNT_W)) u_fsm (
                .clk      (clk),
                .rst_n    (rst_n),
                .wait_vld (wait_vld[t]),
                .wait_sem (wait_sem[t]),
                .wait_thr (wait_thr[t]),
                .grant    (thr_wake[t]),
                .asleep   (thr_asleep[t]),
                .sem_q    (sem_q[t]),
                .thr_q    (thr_q[t])
            );
        end
    endgenerate

    // eligibility and per-semaphore increment sums
    always_comb begin
        for (int si = 0; si < NUM_SEM; si++) begin
            inc[si] = '0;
            for (int ti = 0; ti < NUM_THR; ti++) begin
                req[si][ti] = thr_asleep[ti] && (sem_q[ti] == SEM_W'(si))
                              && (sem_count[si] >= thr_q[ti]);
                if (set_vld[ti] && set_sem[ti] == SEM_W'(si))
                    inc[si] = inc[si] + INC_W'(1);
            end
            if (rmt_vld && rmt_sem == SEM_W'(si)) inc[si] = inc[si] + INC_W'(1);
            if (pkt_vld && pkt_sem == SEM_W'(si)) inc[si] = inc[si] + INC_W'(1);
        end
    end

    // granted threshold per semaphore, wake per thread
    always_comb begin
        thr_wake = '0;
        for (int si = 0; si < NUM_SEM; si++) begin
            sub[si] = '0;
            for (int ti = 0; ti < NUM_THR; ti++) begin
                if (gnt[si][ti]) begin
                    sub[si]      = sub[si] | thr_q[ti];
                    thr_wake[ti] = 1'b1;
                end
            end
        end
    end

    generate
        for (s = 0; s < NUM_SEM; s++) begin : g_sem
            sem_rr_arb #(.N(NUM_THR)) u_arb (
                .clk   (clk),
                .rst_n (rst_n),
                .req   (req[s]),
                .gnt   (gnt[s])
            );
            sem_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (inc[s]),
                .sub   (sub[s]),
                .count (sem_count[s]),
                .ovf   (sem_ovf[s])
            );
        end
    endgenerate
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int NUM_SEM = 4,
    parameter int NUM_THR = 4,
    parameter int CNT_W   = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_THR-1:0]            wait_vld,
    input logic [NUM_THR-1:0]            thr_asleep,
    input logic [NUM_THR-1:0]            thr_wake,
    input logic [NUM_SEM-1:0][CNT_W-1:0] sem_count,
    input logic [NUM_SEM-1:0]            sem_ovf,
    input logic [NUM_SEM-1:0][NUM_THR-1:0] gnt
);
    genvar t, s;
    generate
        for (t = 0; t < NUM_THR; t++) begin : g_t
            AST_WAIT_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                (wait_vld[t] && !thr_asleep[t]) |=> thr_asleep[t]); // R5
            AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
                thr_wake[t] |-> thr_asleep[t]); // R6
            AST_WAKE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
                thr_wake[t] |=> !thr_asleep[t]); // R6
        end
        for (s = 0; s < NUM_SEM; s++) begin : g_s
            AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(gnt[s])); // R7
            AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                sem_ovf[s] |=> sem_ovf[s]); // R8
            AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(sem_ovf[s]) |-> (sem_count[s] == {CNT_W{1'b1}})); // R8
        end
    endgenerate
endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM), .NUM_THR(NUM_THR), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wait_vld   (wait_vld),
    .thr_asleep (thr_asleep),
    .thr_wake   (thr_wake),
    .sem_count  (sem_count),
    .sem_ovf    (sem_ovf),
    .gnt        (gnt)
);

// File: tb/sem_bank_test.sv
module sem_bank_test;
    localparam int NS = 4;
    localparam int NT = 4;
    localparam int CW = 8;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT-1:0]         set_vld = '0;
    logic [NT-1:0][SW-1:0] set_sem = '0;
    logic                  rmt_vld = 1'b0;
    logic [SW-1:0]         rmt_sem = '0;
    logic                  pkt_vld = 1'b0;
    logic [SW-1:0]         pkt_sem = '0;
    logic [NT-1:0]         wait_vld = '0;
    logic [NT-1:0][SW-1:0] wait_sem = '0;
    logic [NT-1:0][CW-1:0] wait_thr = '0;
    logic [NT-1:0]         thr_asleep, thr_wake;
    logic [NS-1:0][CW-1:0] sem_count;
    logic [NS-1:0]         sem_ovf;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sem_bank #(.NUM_SEM(NS), .NUM_THR(NT), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n),
        .set_vld(set_vld), .set_sem(set_sem),
        .rmt_vld(rmt_vld), .rmt_sem(rmt_sem),
        .pkt_vld(pkt_vld), .pkt_sem(pkt_sem),
        .wait_vld(wait_vld), .wait_sem(wait_sem), .wait_thr(wait_thr),
        .thr_asleep(thr_asleep), .thr_wake(thr_wake),
        .sem_count(sem_count), .sem_ovf(sem_ovf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clr();
        set_vld = '0; rmt_vld = 1'b0; pkt_vld = 1'b0; wait_vld = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_wait(input int t, input int s, input int th);
        wait_vld[t] = 1'b1;
        wait_sem[t] = SW'(s);
        wait_thr[t] = CW'(th);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        for (int s = 0; s < NS; s++) chk("R1 count", 32'(sem_count[s]), 0);
        chk("R1 asleep", 32'(thr_asleep), 0);
        chk("R1 wake", 32'(thr_wake), 0);
        chk("R1 ovf", 32'(sem_ovf), 0);
    endtask

    task automatic t_increments();
        set_vld[0] = 1'b1; set_sem[0] = 2'd1;
        step(); clr();
        chk("R2 local set", 32'(sem_count[1]), 1);
        set_vld = '1; set_sem = {NT{2'd1}};
        rmt_vld = 1'b1; rmt_sem = 2'd1;
        pkt_vld = 1'b1; pkt_sem = 2'd1;
        step(); clr();
        chk("R4 summed", 32'(sem_count[1]), 7);
        rmt_vld = 1'b1; rmt_sem = 2'd2;
        pkt_vld = 1'b1; pkt_sem = 2'd3;
        step(); clr();
        chk("R3 remote", 32'(sem_count[2]), 1);
        chk("R3 packet", 32'(sem_count[3]), 1);
        chk("R3 other", 32'(sem_count[1]), 7);
    endtask

    task automatic t_wake_now();
        do_wait(0, 1, 3);
        step(); clr();
        chk("R6 asleep", 32'(thr_asleep[0]), 1);
        chk("R6 wake", 32'(thr_wake), 32'h1);
        step();
        chk("R6 consumed", 32'(sem_count[1]), 4);
        chk("R6 released", 32'(thr_asleep[0]), 0);
        chk("R6 pulse", 32'(thr_wake), 0);
    endtask

    task automatic t_sleep_then_wake();
        do_wait(1, 2, 3);
        step(); clr();
        chk("R5 asleep", 32'(thr_asleep[1]), 1);
        chk("R9 no wake", 32'(thr_wake), 0);
        do_wait(1, 0, 0);
        step(); clr();
        chk("R5 ignored wait", 32'(thr_wake), 0);
        step();
        chk("R5 ignored still", 32'(thr_wake), 0);
        chk("R9 still asleep", 32'(thr_asleep[1]), 1);
        pkt_vld = 1'b1; pkt_sem = 2'd2;
        step();
        chk("R9 below", 32'(thr_wake), 0);
        step(); clr();
        chk("R6 reached", 32'(thr_wake), 32'h2);
        step();
        chk("R6 zero", 32'(sem_count[2]), 0);
        chk("R6 idle", 32'(thr_asleep), 0);
    endtask

    task automatic t_round_robin();
        for (int t = 0; t < NT; t++) do_wait(t, 0, 1);
        step(); clr();
        chk("R9 all asleep", 32'(thr_asleep), 32'hF);
        set_vld = '1; set_sem = '0;
        step(); clr();
        chk("R4 four", 32'(sem_count[0]), 4);
        chk("R7 first", 32'(thr_wake), 32'h1);
        for (int k = 1; k < NT; k++) begin
            step();
            chk("R7 order", 32'(thr_wake), 32'(1 << k));
            chk("R7 count", 32'(sem_count[0]), 32'(4 - k));
        end
        step();
        chk("R7 drained", 32'(sem_count[0]), 0);
        do_wait(1, 0, 1); rmt_vld = 1'b1; rmt_sem = 2'd0;
        step(); clr();
        chk("R7 single", 32'(thr_wake), 32'h2);
        step();
        do_wait(0, 0, 1); do_wait(2, 0, 1);
        step(); clr();
        rmt_vld = 1'b1; rmt_sem = 2'd0;
        step();
        chk("R7 after last", 32'(thr_wake), 32'h4);
        step(); clr();
        chk("R7 wrap", 32'(thr_wake), 32'h1);
        step();
        chk("R7 empty", 32'(sem_count[0]), 0);
        chk("R7 none asleep", 32'(thr_asleep), 0);
    endtask

    task automatic t_collide();
        rmt_vld = 1'b1; rmt_sem = 2'd2; pkt_vld = 1'b1; pkt_sem = 2'd2;
        step(); clr();
        do_wait(1, 2, 2);
        step(); clr();
        chk("R6 coll wake", 32'(thr_wake), 32'h2);
        rmt_vld = 1'b1; rmt_sem = 2'd2;
        step(); clr();
        chk("R6 coll count", 32'(sem_count[2]), 1);
        chk("R6 coll idle", 32'(thr_asleep[1]), 0);
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 50; k++) begin
            set_vld = '1; set_sem = {NT{2'd3}};
            rmt_vld = 1'b1; rmt_sem = 2'd3; pkt_vld = 1'b1; pkt_sem = 2'd3;
            step();
        end
        clr();
        chk("R8 clamp", 32'(sem_count[3]), 255);
        chk("R8 flag", 32'(sem_ovf), 32'h8);
        do_wait(0, 3, 5);
        step(); clr();
        chk("R8 wake", 32'(thr_wake), 32'h1);
        step();
        chk("R8 after", 32'(sem_count[3]), 250);
        chk("R8 sticky", 32'(sem_ovf[3]), 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_increments();
        t_wake_now();
        t_sleep_then_wake();
        t_round_robin();
        t_collide();
        t_saturate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule